// File: doc/BRIEF.md
# Ethernet MAC Interrupt Status and Acknowledge Register

This block holds the raw interrupt state of a small Ethernet MAC. Seven event sources each set a sticky status bit: packet received, transmit error, transmit FIFO empty, receive FIFO overrun, receive error, management transaction complete and PHY interrupt. Software reads the status word unmasked and acknowledges bits by writing ones to them. A separate mask word decides which status bits drive the single interrupt output.

Two status sources are qualified inside the block. A transmit error is raised when the frame length loaded into the transmit FIFO is above a limit, in which case a drop-frame pulse tells the transmitter to skip the frame, or when the backoff retry count is above a limit. A receive error is the merge of four receive fault strobes. Acknowledging the transmit error bit also sends a one-cycle reset pulse to the transmit FIFO write pointer.

Top module: `mac_irq_status`

## Requirements
- R1: Address `reg_sel`=0 selects the status word: bit 0 packet received, bit 1 transmit error, bit 2 transmit FIFO empty, bit 3 receive FIFO overrun, bit 4 receive error, bit 5 management transaction complete, bit 6 PHY interrupt; bits 31:7 read as zero and writes to them have no effect.
- R2: A status read returns the raw bits whatever the mask holds.
- R3: A write to the status word clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R4: A status write with bit 1 set drives `tx_wptr_rst` high for exactly the one cycle after the write edge; writes without bit 1, or to the mask word, do not.
- R5: A length strobe with a length above 2032 sets status bit 1 and pulses `drop_frame` for one cycle, both visible after the same edge; a length of exactly 2032 does neither.
- R6: A retry strobe with a count above 16 sets status bit 1 without `drop_frame`; a count of exactly 16 has no effect.
- R7: Status bit 4 is set by a dribble, FCS or length-mismatch strobe, and by a PHY receive error strobe only while `speed_100` is 1.
- R8: After reset the status word, the mask word, `irq`, `tx_wptr_rst` and `drop_frame` are all zero.
- R9: When an event and a write-1 clear hit the same status bit in the same cycle, the bit ends set.
- R10: A status bit set by a one-cycle event stays set until it is cleared by a write.
- R11: Address `reg_sel`=1 is the mask word (bits 6:0 writable, 31:7 read zero); `irq` is high exactly when some status bit and its mask bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 1 | 0 = status word, 1 = mask word |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data of the selected word |
| ev_rx_pkt | input | 1 | Packet received pulse |
| ev_tx_empty | input | 1 | Transmit FIFO empty pulse |
| ev_rx_ovf | input | 1 | Receive FIFO overrun pulse |
| ev_mgmt_done | input | 1 | Management transaction complete pulse |
| ev_phy_irq | input | 1 | PHY interrupt pulse |
| speed_100 | input | 1 | Link runs at 100 Mb/s |
| rx_phy_err | input | 1 | PHY receive error strobe |
| rx_dribble | input | 1 | Frame not a whole number of bytes |
| rx_fcs_bad | input | 1 | FCS check failed |
| rx_len_bad | input | 1 | Length field disagrees with data size |
| tx_len_vld | input | 1 | Frame length strobe |
| tx_len | input | 12 | Frame data length |
| tx_rty_vld | input | 1 | Retry count strobe |
| tx_rty_cnt | input | 5 | Backoff retry count |
| irq | output | 1 | Masked interrupt |
| tx_wptr_rst | output | 1 | Transmit FIFO write pointer reset pulse |
| drop_frame | output | 1 | Skip the current transmit frame |

## Verification
The event that sets a status bit and the software write that clears it can land on the same edge, and the acknowledge of bit 1 can coincide with a fresh length error. The bench provokes both by raising the event strobe and the write strobe in one cycle, including an oversize frame together with a bit-1 acknowledge. It judges them with a behavioural model in which setting overrides clearing, expecting the bit to stay set while the pointer reset pulse still fires.

// File: rtl/mac_irq_pkg.sv
// Package: shared constants and types for the MAC interrupt status block.
// Assumes a 7-source status word; bit order is fixed because software decodes it.
package mac_irq_pkg;
    localparam int NSRC = 7;

    localparam int BIT_RX_PKT   = 0;
    localparam int BIT_TX_ERR   = 1;
    localparam int BIT_TX_EMPTY = 2;
    localparam int BIT_RX_OVF   = 3;
    localparam int BIT_RX_ERR   = 4;
    localparam int BIT_MGMT     = 5;
    localparam int BIT_PHY      = 6;

    typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/mac_irq_txerr_qual.sv
// Module: transmit error qualifier.
// Flags a frame whose length is above LEN_LIMIT (and registers a drop pulse for it)
// or a retry count above RTY_LIMIT. Assumes both strobes are one cycle wide.
module mac_irq_txerr_qual #(
    parameter int LEN_W     = 12,
    parameter int LEN_LIMIT = 2032,
    parameter int RTY_W     = 5,
    parameter int RTY_LIMIT = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             len_vld,
    input  logic [LEN_W-1:0] len,
    input  logic             rty_vld,
    input  logic [RTY_W-1:0] rty_cnt,
    output logic             tx_err_ev,
    output logic             drop_frame
);
    localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(LEN_LIMIT);
    localparam logic [RTY_W-1:0] RTY_MAX = RTY_W'(RTY_LIMIT);

    logic len_over;
    logic rty_over;

    // Compare the strobed values against their limits.
    always_comb begin
        len_over  = len_vld && (len > LEN_MAX);
        rty_over  = rty_vld && (rty_cnt > RTY_MAX);
        tx_err_ev = len_over || rty_over;
    end

    // Register the drop pulse so it appears with the status bit.
    always_ff @(posedge clk) begin
        if (!rst_n) drop_frame <= 1'b0;
        else        drop_frame <= len_over;
    end
endmodule

// File: rtl/mac_irq_rxerr_merge.sv
// Module: receive error merge.
// Combines the four receive fault strobes into one event; the PHY error counts
// only at 100 Mb/s. Assumes strobes are synchronous to clk.
module mac_irq_rxerr_merge (
    input  logic speed_100,
    input  logic phy_err,
    input  logic dribble,
    input  logic fcs_bad,
    input  logic len_bad,
    output logic rx_err_ev
);
    // OR the qualified fault strobes.
    always_comb begin
        rx_err_ev = (phy_err && speed_100) || dribble || fcs_bad || len_bad;
    end
endmodule

// File: rtl/mac_irq_sticky_bit.sv
// Module: one sticky status bit.
// Set by an event pulse, cleared by an acknowledge; setting wins over clearing.
module mac_irq_sticky_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    // Hold the bit; set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= 1'b0;
        else if (set) q <= 1'b1;
        else if (clr) q <= 1'b0;
    end
endmodule

// File: rtl/mac_irq_status.sv
// Module: MAC raw interrupt status / acknowledge register (top).
// Holds seven sticky status bits, a mask word and the masked interrupt output.
// Assumes single-cycle event pulses and a one-cycle write strobe.
module mac_irq_status #(
    parameter int DATA_W    = 32,
    parameter int LEN_W     = 12,
    parameter int LEN_LIMIT = 2032,
    parameter int RTY_W     = 5,
    parameter int RTY_LIMIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              ev_rx_pkt,
    input  logic              ev_tx_empty,
    input  logic              ev_rx_ovf,
    input  logic              ev_mgmt_done,
    input  logic              ev_phy_irq,
    input  logic              speed_100,
    input  logic              rx_phy_err,
    input  logic              rx_dribble,
    input  logic              rx_fcs_bad,
    input  logic              rx_len_bad,
    input  logic              tx_len_vld,
    input  logic [LEN_W-1:0]  tx_len,
    input  logic              tx_rty_vld,
    input  logic [RTY_W-1:0]  tx_rty_cnt,
    output logic              irq,
    output logic              tx_wptr_rst,
    output logic              drop_frame
);
    import mac_irq_pkg::*;

    src_vec_t status_q;
    src_vec_t mask_q;
    src_vec_t set_vec;
    src_vec_t clr_vec;
    logic     tx_err_ev;
    logic     rx_err_ev;
    logic     wr_status;
    logic     wr_mask;
    logic     unused_hi;

    assign unused_hi = ^wr_data[DATA_W-1:NSRC];

    mac_irq_txerr_qual #(
        .LEN_W(LEN_W), .LEN_LIMIT(LEN_LIMIT),
        .RTY_W(RTY_W), .RTY_LIMIT(RTY_LIMIT)
    ) u_txq (
        .clk(clk), .rst_n(rst_n),
        .len_vld(tx_len_vld), .len(tx_len),
        .rty_vld(tx_rty_vld), .rty_cnt(tx_rty_cnt),
        .tx_err_ev(tx_err_ev), .drop_frame(drop_frame)
    );

    mac_irq_rxerr_merge u_rxm (
        .speed_100(speed_100), .phy_err(rx_phy_err), .dribble(rx_dribble),
        .fcs_bad(rx_fcs_bad), .len_bad(rx_len_bad), .rx_err_ev(rx_err_ev)
    );

    // Decode writes and place each event on its status bit.
    always_comb begin
        wr_status             = wr_en && !reg_sel;
        wr_mask               = wr_en && reg_sel;
        set_vec               = '0;
        set_vec[BIT_RX_PKT]   = ev_rx_pkt;
        set_vec[BIT_TX_ERR]   = tx_err_ev;
        set_vec[BIT_TX_EMPTY] = ev_tx_empty;
        set_vec[BIT_RX_OVF]   = ev_rx_ovf;
        set_vec[BIT_RX_ERR]   = rx_err_ev;
        set_vec[BIT_MGMT]     = ev_mgmt_done;
        set_vec[BIT_PHY]      = ev_phy_irq;
        clr_vec               = wr_status ? wr_data[NSRC-1:0] : '0;
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_bit
        mac_irq_sticky_bit u_bit (
            .clk(clk), .rst_n(rst_n),
            .set(set_vec[i]), .clr(clr_vec[i]), .q(status_q[i])
        );
    end

    // Mask word and the write-pointer reset pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q      <= '0;
            tx_wptr_rst <= 1'b0;
        end else begin
            if (wr_mask) mask_q <= wr_data[NSRC-1:0];
            tx_wptr_rst <= wr_status && wr_data[BIT_TX_ERR];
        end
    end

    // Read mux and masked interrupt.
    always_comb begin
        rd_data = reg_sel ? DATA_W'(mask_q) : DATA_W'(status_q);
        irq     = |(status_q & mask_q);
    end
endmodule

// Checker: protocol properties of mac_irq_status, attached by bind below.
module mac_irq_status_chk #(
    parameter int DATA_W    = 32,
    parameter int LEN_W     = 12,
    parameter int LEN_LIMIT = 2032,
    parameter int NSRC      = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_sel,
    input logic              wr_en,
    input logic [NSRC-1:0]   wr_lo,
    input logic [DATA_W-1:0] rd_data,
    input logic              ev_rx_pkt,
    input logic              ev_tx_empty,
    input logic              tx_len_vld,
    input logic [LEN_W-1:0]  tx_len,
    input logic [NSRC-1:0]   status_q,
    input logic              tx_wptr_rst,
    input logic              drop_frame
);
    localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(LEN_LIMIT);

    a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[DATA_W-1:NSRC] == '0);
    a_r3_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !reg_sel && wr_lo[0] && !ev_rx_pkt) |=> !status_q[0]);
    a_r4_ptr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !reg_sel && wr_lo[1]) |=> tx_wptr_rst);
    a_r4_ptr_cause: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wptr_rst |-> $past(wr_en && !reg_sel && wr_lo[1]));
    a_r5_len_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_len_vld && tx_len > LEN_MAX) |=> (drop_frame && status_q[1]));
    a_r9_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rx_pkt |=> status_q[0]);
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q[2] && !(wr_en && !reg_sel && wr_lo[2])) |=> status_q[2]);
    a_r10_set_by_event: assert property (@(posedge clk) disable iff (!rst_n)
        ev_tx_empty |=> status_q[2]);
endmodule

bind mac_irq_status mac_irq_status_chk #(
    .DATA_W(DATA_W), .LEN_W(LEN_W), .LEN_LIMIT(LEN_LIMIT), .NSRC(mac_irq_pkg::NSRC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
    .wr_lo(wr_data[mac_irq_pkg::NSRC-1:0]), .rd_data(rd_data),
    .ev_rx_pkt(ev_rx_pkt), .ev_tx_empty(ev_tx_empty),
    .tx_len_vld(tx_len_vld), .tx_len(tx_len), .status_q(status_q),
    .tx_wptr_rst(tx_wptr_rst), .drop_frame(drop_frame)
);

// File: tb/test_mac_irq_status.sv
// Bench: behavioural reference model compared every clock, plus directed checks.
module test_mac_irq_status;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_sel = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic ev_rx_pkt = 0, ev_tx_empty = 0, ev_rx_ovf = 0, ev_mgmt_done = 0, ev_phy_irq = 0;
    logic speed_100 = 0, rx_phy_err = 0, rx_dribble = 0, rx_fcs_bad = 0, rx_len_bad = 0;
    logic        tx_len_vld = 0;
    logic [11:0] tx_len = '0;
    logic        tx_rty_vld = 0;
    logic [4:0]  tx_rty_cnt = '0;
    logic        irq, tx_wptr_rst, drop_frame;

    int n_cmp = 0;
    int n_bad = 0;

    mac_irq_status i_mac_irq_status (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data),
        .ev_rx_pkt(ev_rx_pkt), .ev_tx_empty(ev_tx_empty), .ev_rx_ovf(ev_rx_ovf),
        .ev_mgmt_done(ev_mgmt_done), .ev_phy_irq(ev_phy_irq),
        .speed_100(speed_100), .rx_phy_err(rx_phy_err), .rx_dribble(rx_dribble),
        .rx_fcs_bad(rx_fcs_bad), .rx_len_bad(rx_len_bad),
        .tx_len_vld(tx_len_vld), .tx_len(tx_len),
        .tx_rty_vld(tx_rty_vld), .tx_rty_cnt(tx_rty_cnt),
        .irq(irq), .tx_wptr_rst(tx_wptr_rst), .drop_frame(drop_frame)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model state, written from the requirements.
    logic [6:0] m_stat = '0, m_mask = '0;
    logic       m_ptr = 0, m_drop = 0;

    always @(posedge clk) begin
        logic [6:0] setv, clrv;
        if (!rst_n) begin
            m_stat <= '0; m_mask <= '0; m_ptr <= 0; m_drop <= 0;
        end else begin
            setv = '0;
            setv[0] = ev_rx_pkt;
            setv[1] = (tx_len_vld && tx_len > 2032) || (tx_rty_vld && tx_rty_cnt > 16);
            setv[2] = ev_tx_empty;
            setv[3] = ev_rx_ovf;
            setv[4] = (rx_phy_err && speed_100) || rx_dribble || rx_fcs_bad || rx_len_bad;
            setv[5] = ev_mgmt_done;
            setv[6] = ev_phy_irq;
            clrv = (wr_en && !reg_sel) ? wr_data[6:0] : '0;
            m_stat <= (m_stat & ~clrv) | setv;
            if (wr_en && reg_sel) m_mask <= wr_data[6:0];
            m_ptr  <= wr_en && !reg_sel && wr_data[1];
            m_drop <= tx_len_vld && tx_len > 2032;
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    // Per-clock comparison away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R3 R1 R11 rd_data", rd_data, reg_sel ? {25'd0, m_mask} : {25'd0, m_stat});
            chk("R11 irq", {31'd0, irq}, {31'd0, |(m_stat & m_mask)});
            chk("R4 tx_wptr_rst", {31'd0, tx_wptr_rst}, {31'd0, m_ptr});
            chk("R5 drop_frame", {31'd0, drop_frame}, {31'd0, m_drop});
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic quiet();
        ev_rx_pkt = 0; ev_tx_empty = 0; ev_rx_ovf = 0; ev_mgmt_done = 0; ev_phy_irq = 0;
        rx_phy_err = 0; rx_dribble = 0; rx_fcs_bad = 0; rx_len_bad = 0;
        tx_len_vld = 0; tx_rty_vld = 0; wr_en = 0;
    endtask

    task automatic wr(input logic sel, input logic [31:0] d);
        reg_sel = sel; wr_en = 1; wr_data = d;
        tick();
        wr_en = 0;
    endtask

    task automatic rd(input logic sel, output logic [31:0] v);
        reg_sel = sel; #1; v = rd_data;
    endtask

    logic [31:0] v;

    initial begin
        #(CLK_PERIOD * 50000);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1; tick();
        // R8 reset state
        rd(0, v); chk("R8 status", v, 0);
        rd(1, v); chk("R8 mask", v, 0);
        chk("R8 irq/ptr/drop", {29'd0, irq, tx_wptr_rst, drop_frame}, 0);

        // R1 bit positions of the direct events
        ev_rx_pkt = 1; tick(); quiet(); rd(0, v); chk("R1 bit0", v, 32'h01); wr(0, 32'h7F);
        ev_tx_empty = 1; tick(); quiet(); rd(0, v); chk("R1 bit2", v, 32'h04); wr(0, 32'h7F);
        ev_rx_ovf = 1; tick(); quiet(); rd(0, v); chk("R1 bit3", v, 32'h08); wr(0, 32'h7F);
        ev_mgmt_done = 1; tick(); quiet(); rd(0, v); chk("R1 bit5", v, 32'h20); wr(0, 32'h7F);
        ev_phy_irq = 1; tick(); quiet(); rd(0, v); chk("R1 bit6", v, 32'h40); wr(0, 32'h7F);
        rd(0, v); chk("R3 all cleared", v, 0);

        // R10 sticky and R3 selective clear
        ev_rx_pkt = 1; ev_tx_empty = 1; ev_rx_ovf = 1; tick(); quiet();
        repeat (4) tick();
        rd(0, v); chk("R10 sticky", v, 32'h0D);
        wr(0, 32'h05); rd(0, v); chk("R3 partial clear", v, 32'h08);
        wr(0, 32'h00); rd(0, v); chk("R3 zero write", v, 32'h08);
        wr(0, 32'hFFFF_FF80); rd(0, v); chk("R1 reserved write", v, 32'h08);
        wr(0, 32'h7F);

        // R11 mask, R2 raw read
        wr(1, 32'hFFFF_FF84); rd(1, v); chk("R11 mask readback", v, 32'h04);
        chk("R11 irq idle", {31'd0, irq}, 0);
        ev_tx_empty = 1; ev_rx_pkt = 1; tick(); quiet();
        chk("R11 irq set", {31'd0, irq}, 1);
        rd(0, v); chk("R2 raw read", v, 32'h05);
        wr(0, 32'h04); chk("R11 irq masked off", {31'd0, irq}, 0);
        wr(0, 32'h7F); wr(1, 32'h0);

        // R4 pointer reset pulse
        wr(0, 32'h02); chk("R4 pulse", {31'd0, tx_wptr_rst}, 1);
        tick(); chk("R4 one cycle", {31'd0, tx_wptr_rst}, 0);
        wr(0, 32'h01); chk("R4 no bit1", {31'd0, tx_wptr_rst}, 0);
        wr(1, 32'h02); chk("R4 mask write", {31'd0, tx_wptr_rst}, 0);
        wr(1, 32'h00);

        // R5 length limit
        tx_len = 12'd2032; tx_len_vld = 1; tick(); quiet();
        rd(0, v); chk("R5 2032 no err", v, 0); chk("R5 2032 no drop", {31'd0, drop_frame}, 0);
        tx_len = 12'd2033; tx_len_vld = 1; tick(); quiet();
        rd(0, v); chk("R5 2033 err", v, 32'h02); chk("R5 drop", {31'd0, drop_frame}, 1);
        tick(); chk("R5 drop one cycle", {31'd0, drop_frame}, 0);
        wr(0, 32'h7F);

        // R6 retry limit
        tx_rty_cnt = 5'd16; tx_rty_vld = 1; tick(); quiet();
        rd(0, v); chk("R6 16 no err", v, 0);
        tx_rty_cnt = 5'd17; tx_rty_vld = 1; tick(); quiet();
        rd(0, v); chk("R6 17 err", v, 32'h02); chk("R6 no drop", {31'd0, drop_frame}, 0);
        wr(0, 32'h7F);

        // R7 receive error sources
        speed_100 = 0; rx_phy_err = 1; tick(); quiet();
        rd(0, v); chk("R7 phy err at 10M", v, 0);
        speed_100 = 1; rx_phy_err = 1; tick(); quiet();
        rd(0, v); chk("R7 phy err at 100M", v, 32'h10); wr(0, 32'h10);
        rx_dribble = 1; tick(); quiet(); rd(0, v); chk("R7 dribble", v, 32'h10); wr(0, 32'h10);
        rx_fcs_bad = 1; tick(); quiet(); rd(0, v); chk("R7 fcs", v, 32'h10); wr(0, 32'h10);
        rx_len_bad = 1; tick(); quiet(); rd(0, v); chk("R7 len mismatch", v, 32'h10); wr(0, 32'h10);

        // R9 event and clear in the same cycle
        ev_rx_pkt = 1; tick(); quiet();
        ev_rx_pkt = 1; wr(0, 32'h01); quiet();
        rd(0, v); chk("R9 event wins", v, 32'h01);
        tx_len = 12'd4000; tx_len_vld = 1; wr(0, 32'h03); quiet();
        rd(0, v); chk("R9 tx err wins", v, 32'h02);
        chk("R9 ptr still pulses", {31'd0, tx_wptr_rst}, 1);
        wr(0, 32'h7F); rd(0, v); chk("R3 final clear", v, 0);

        repeat (3) tick();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule